// File: doc/BRIEF.md
# Interval Timer Control and Read-Back Unit

This block is the host-side control logic of a three-channel, 16-bit down-counting interval timer. The host sees four byte-wide locations. Addresses 0, 1 and 2 are the count locations of channels 0 to 2, and address 3 is a shared control location. A write to the control location does one of three things. It can program one channel's access format, counting mode and binary/BCD setting. It can freeze one channel's count (counter latch). It can freeze the count and/or the status byte of any set of channels in one step (read-back).

Writes to a channel address assemble a new count according to the channel's access format and transfer it into the channel's counting core. Reads from a channel address return, in order of priority: a pending latched status byte, then the pending latched count bytes, and otherwise the live count. The counting cores are plain decrementers that run while their enable input is high. Each core reports its count, its OUT level and a null-count flag, so that latching and status can be observed.

Top module: `itmr_ctrl`

## Requirements
- R1: A control write (address 3) whose bits [7:6] are 00, 01 or 10 and whose bits [5:4] are not 00 stores bits [5:0] for channel 0, 1 or 2. Bits [5:4] are the access format: 01 low byte, 10 high byte, 11 low then high. Bits [3:1] are the mode. Bit 0 selects BCD (1) or binary (0).
- R2: Output `mode_o[3i+2:3i]` gives channel i's decoded mode. Mode bits 000, 001, 100 and 101 give modes 0, 1, 4 and 5. Mode bits x10 give 2 and x11 give 3, whatever the top bit is.
- R3: Count writes follow the stored format. Low-byte format loads {00,byte}. High-byte format loads {byte,00}. Low-then-high format loads {second byte, first byte} on the second write. The core takes the value at the clock edge of the completing write, and null count clears at that edge.
- R4: A control write to a channel sets its null count, drives its OUT low, resets both its read and write byte pointers, and drops any pending latch on it.
- R5: A control write with bits [5:4] = 00 latches that channel's count. Later reads return the latched value in the stored format (one byte, or low then high). After that, reads return the live count again.
- R6: While a channel's count latch is pending, any further count latch on it is ignored, whether by latch command or by read-back. The same holds for a pending status latch.
- R7: A control write with bits [7:6] = 11 is a read-back. Bits 3, 2 and 1 select channels 2, 1 and 0. Bit 5 = 0 latches the count and bit 4 = 0 latches the status of every selected channel. If bit 0 is 1, the whole command is ignored.
- R8: The status byte is {OUT, null count, stored bits [5:0]}. When both status and count are pending, the first read returns the status and the following reads return the count.
- R9: With nothing latched, a channel read returns the live count in the stored format. In low-then-high format the bytes alternate low, high, low...
- R10: While its enable is high and a count has been loaded since the last control write, a core decrements once per clock. A binary count wraps from 0x0000 to 0xFFFF. A BCD count borrows per decimal digit and wraps from 0000 to 9999.
- R11: A channel's OUT goes high on the clock edge where its count steps from 1 to 0. It stays high until the next control write to that channel.
- R12: After reset, all stored settings, counts, latches and pointers are zero. OUT is low and `mode_o` is 0.
- R13: A read from address 3 returns 0x00 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, acts at the rising clock edge |
| rd_en | input | 1 | Read strobe; the read advances pointers and releases latches at the rising edge |
| addr | input | 2 | 0 to 2: channel count location; 3: control location |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, valid combinationally before the edge that consumes it |
| cnt_en | input | 3 | Per-channel decrement enable |
| out_lvl | output | 3 | Per-channel OUT level |
| mode_o | output | 9 | Decoded mode, 3 bits per channel |

## Verification
A fault in the latch-valid flags shows up on the very next channel read. A latch that was wrongly taken again returns a newer count. A latch released too early hands the live count over in the middle of a two-byte read. A byte-pointer fault swaps low and high bytes on the second read after a control write. A fault in the null-count or OUT state is seen at the first read-back status read after the cause. A BCD borrow fault shows up as a non-decimal digit in the live count one clock after the wrap.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    localparam int unsigned NCH      = 3;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned CNT_W    = 2 * BYTE_W;
    localparam int unsigned DIGITS   = CNT_W / 4;
    localparam int unsigned MODE_W   = 3;
    localparam logic [1:0]  CTRL_ADR = 2'd3;

    typedef enum logic [1:0] {
        FMT_LATCH = 2'b00,
        FMT_LO    = 2'b01,
        FMT_HI    = 2'b10,
        FMT_LOHI  = 2'b11
    } fmt_e;

    // Layout matches control word bits [5:0]; the status byte echoes it.
    typedef struct packed {
        fmt_e       fmt;
        logic [2:0] mode_raw;
        logic       bcd;
    } ctrl_t;

    typedef struct packed {
        logic  ctrl_wr;
        logic  latch_cmd;
        logic  rb_cnt;
        logic  rb_st;
        ctrl_t cw;
    } chan_cmd_t;

    function automatic logic [MODE_W-1:0] mode_of(input logic [2:0] raw);
        logic [MODE_W-1:0] m;
        if (raw[1]) m = {2'b01, raw[0]};
        else        m = raw;
        return m;
    endfunction

    function automatic logic [CNT_W-1:0] bcd_dec(input logic [CNT_W-1:0] v);
        logic [CNT_W-1:0] r;
        logic             brw;
        r   = v;
        brw = 1'b1;
        for (int d = 0; d < DIGITS; d++) begin
            if (brw) begin
                if (r[d*4 +: 4] == 4'd0) begin
                    r[d*4 +: 4] = 4'd9;
                end else begin
                    r[d*4 +: 4] = r[d*4 +: 4] - 4'd1;
                    brw = 1'b0;
                end
            end
        end
        return r;
    endfunction

    function automatic logic is_bcd(input logic [CNT_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int d = 0; d < DIGITS; d++) begin
            if (v[d*4 +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/itmr_decode.sv
module itmr_decode
    import itmr_pkg::*;
(
    input  logic                  wr_en,
    input  logic [1:0]            addr,
    input  logic [BYTE_W-1:0]     wdata,
    output chan_cmd_t [NCH-1:0]   cmd,
    output logic [NCH-1:0]        wr_cnt
);

    logic ctrl_sel;
    logic is_rb;
    logic rb_valid;

    always_comb begin
        ctrl_sel = wr_en && (addr == CTRL_ADR);
        is_rb    = (wdata[7:6] == 2'b11);
        rb_valid = ctrl_sel && is_rb && !wdata[0];
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit_ch;
        always_comb begin
            hit_ch              = ctrl_sel && !is_rb && (wdata[7:6] == 2'(i));
            cmd[i].ctrl_wr      = hit_ch && (wdata[5:4] != 2'b00);
            cmd[i].latch_cmd    = hit_ch && (wdata[5:4] == 2'b00);
            cmd[i].rb_cnt       = rb_valid && wdata[1+i] && !wdata[5];
            cmd[i].rb_st        = rb_valid && wdata[1+i] && !wdata[4];
            cmd[i].cw           = ctrl_t'(wdata[5:0]);
            wr_cnt[i]           = wr_en && (addr == 2'(i));
        end
    end

endmodule

// File: rtl/itmr_core.sv
module itmr_core
    import itmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             en,
    input  logic             bcd,
    output logic [CNT_W-1:0] count,
    output logic             out_o,
    output logic             null_o
);

    logic             armed_q;
    logic [CNT_W-1:0] next_cnt;

    always_comb begin
        if (bcd) next_cnt = bcd_dec(count);
        else     next_cnt = count - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            armed_q <= 1'b0;
            out_o   <= 1'b0;
            null_o  <= 1'b0;
        end else if (clr) begin
            armed_q <= 1'b0;
            out_o   <= 1'b0;
            null_o  <= 1'b1;
        end else if (ld) begin
            count   <= ld_val;
            armed_q <= 1'b1;
            null_o  <= 1'b0;
        end else if (en && armed_q) begin
            count <= next_cnt;
            if (count == CNT_W'(1)) out_o <= 1'b1;
        end
    end

    // R11: OUT stays high until cleared by a control write
    p_out_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (out_o && !clr) |=> out_o);

    // R10: decrementing a valid BCD count yields a valid BCD count
    p_bcd_keep_r10: assert property (@(posedge clk) disable iff (rst)
        (bcd && en && armed_q && !ld && !clr && is_bcd(count)) |=> is_bcd(count));

endmodule

// File: rtl/itmr_chan.sv
module itmr_chan
    import itmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  chan_cmd_t         cmd,
    input  logic              wr_cnt,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rd_hit,
    input  logic              cnt_en,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [MODE_W-1:0] mode,
    output logic              out_lvl
);

    ctrl_t             ctrl_q;
    logic              wr_hi_q;
    logic              rd_hi_q;
    logic [BYTE_W-1:0] lo_hold_q;
    logic [CNT_W-1:0]  cnt_lat_q;
    logic              cnt_lat_v;
    logic [BYTE_W-1:0] st_lat_q;
    logic              st_lat_v;

    logic              ld;
    logic [CNT_W-1:0]  ld_val;
    logic [CNT_W-1:0]  live_cnt;
    logic              null_c;
    logic [BYTE_W-1:0] status_w;
    logic [CNT_W-1:0]  src_cnt;

    itmr_core u_core (
        .clk    (clk),
        .rst    (rst),
        .clr    (cmd.ctrl_wr),
        .ld     (ld),
        .ld_val (ld_val),
        .en     (cnt_en),
        .bcd    (ctrl_q.bcd),
        .count  (live_cnt),
        .out_o  (out_lvl),
        .null_o (null_c)
    );

    // Count assembly according to the stored access format
    always_comb begin
        ld     = 1'b0;
        ld_val = '0;
        unique case (ctrl_q.fmt)
            FMT_LO: begin
                ld     = wr_cnt;
                ld_val = {{BYTE_W{1'b0}}, wdata};
            end
            FMT_HI: begin
                ld     = wr_cnt;
                ld_val = {wdata, {BYTE_W{1'b0}}};
            end
            FMT_LOHI: begin
                ld     = wr_cnt && wr_hi_q;
                ld_val = {wdata, lo_hold_q};
            end
            default: begin
                ld     = 1'b0;
                ld_val = '0;
            end
        endcase
    end

    // Read data: pending status, then pending count, then live count
    always_comb begin
        status_w = {out_lvl, null_c, ctrl_q};
        src_cnt  = cnt_lat_v ? cnt_lat_q : live_cnt;
        if (st_lat_v) begin
            rd_byte = st_lat_q;
        end else begin
            unique case (ctrl_q.fmt)
                FMT_HI:   rd_byte = src_cnt[CNT_W-1:BYTE_W];
                FMT_LOHI: rd_byte = rd_hi_q ? src_cnt[CNT_W-1:BYTE_W] : src_cnt[BYTE_W-1:0];
                default:  rd_byte = src_cnt[BYTE_W-1:0];
            endcase
        end
        mode = mode_of(ctrl_q.mode_raw);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            wr_hi_q   <= 1'b0;
            rd_hi_q   <= 1'b0;
            lo_hold_q <= '0;
            cnt_lat_q <= '0;
            cnt_lat_v <= 1'b0;
            st_lat_q  <= '0;
            st_lat_v  <= 1'b0;
        end else if (cmd.ctrl_wr) begin
            ctrl_q    <= cmd.cw;
            wr_hi_q   <= 1'b0;
            rd_hi_q   <= 1'b0;
            cnt_lat_v <= 1'b0;
            st_lat_v  <= 1'b0;
        end else begin
            if (wr_cnt && ctrl_q.fmt == FMT_LOHI) begin
                if (!wr_hi_q) lo_hold_q <= wdata;
                wr_hi_q <= !wr_hi_q;
            end
            if (rd_hit) begin
                if (st_lat_v) begin
                    st_lat_v <= 1'b0;
                end else begin
                    if (ctrl_q.fmt == FMT_LOHI) rd_hi_q <= !rd_hi_q;
                    if (cnt_lat_v && (ctrl_q.fmt != FMT_LOHI || rd_hi_q))
                        cnt_lat_v <= 1'b0;
                end
            end
            if ((cmd.latch_cmd || cmd.rb_cnt) && !cnt_lat_v) begin
                cnt_lat_q <= live_cnt;
                cnt_lat_v <= 1'b1;
            end
            if (cmd.rb_st && !st_lat_v) begin
                st_lat_q <= status_w;
                st_lat_v <= 1'b1;
            end
        end
    end

    // R3: transfer into the core clears null count
    p_ld_clears_null_r3: assert property (@(posedge clk) disable iff (rst)
        (ld && !cmd.ctrl_wr) |=> !null_c);

    // R4: control write raises null count and drops OUT
    p_ctrl_sets_null_r4: assert property (@(posedge clk) disable iff (rst)
        cmd.ctrl_wr |=> (null_c && !out_lvl));

    // R6: a pending count latch is held until read out or reprogrammed
    p_latch_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (cnt_lat_v && !cmd.ctrl_wr && !rd_hit) |=> (cnt_lat_v && $stable(cnt_lat_q)));

    // R8: reading the status byte leaves a pending count untouched
    p_status_first_r8: assert property (@(posedge clk) disable iff (rst)
        (st_lat_v && rd_hit && !cmd.ctrl_wr) |=> (cnt_lat_v == $past(cnt_lat_v)));

endmodule

// File: rtl/itmr_ctrl.sv
module itmr_ctrl
    import itmr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [1:0]            addr,
    input  logic [BYTE_W-1:0]     wdata,
    output logic [BYTE_W-1:0]     rdata,
    input  logic [NCH-1:0]        cnt_en,
    output logic [NCH-1:0]        out_lvl,
    output logic [NCH*MODE_W-1:0] mode_o
);

    chan_cmd_t [NCH-1:0]               cmd;
    logic [NCH-1:0]                    wr_cnt;
    logic [NCH-1:0]                    rd_hit;
    logic [NCH-1:0][BYTE_W-1:0]        rd_bytes;

    itmr_decode u_dec (
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .cmd    (cmd),
        .wr_cnt (wr_cnt)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        assign rd_hit[i] = rd_en && (addr == 2'(i));
        itmr_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .cmd     (cmd[i]),
            .wr_cnt  (wr_cnt[i]),
            .wdata   (wdata),
            .rd_hit  (rd_hit[i]),
            .cnt_en  (cnt_en[i]),
            .rd_byte (rd_bytes[i]),
            .mode    (mode_o[i*MODE_W +: MODE_W]),
            .out_lvl (out_lvl[i])
        );
    end

    // R13: control location reads as zero
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (addr == 2'(i)) rdata = rd_bytes[i];
        end
    end

endmodule

// File: tb/itmr_ctrl_bench.sv
module itmr_ctrl_bench;
    import itmr_pkg::*;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en, rd_en;
    logic [1:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic [2:0] cnt_en;
    logic [2:0] out_lvl;
    logic [8:0] mode_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    itmr_ctrl u_itmr_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cnt_en(cnt_en), .out_lvl(out_lvl),
        .mode_o(mode_o)
    );

    // {op, addr, data, requirement}: op 0 = write, 1 = read and compare
    localparam int NV = 39;
    localparam logic [19:0] VEC [NV] = '{
        {2'd0, 2'd3, 8'h36, 8'd1},   // R1 ch0 low/high, mode 3, binary
        {2'd0, 2'd0, 8'h34, 8'd3},   // R3
        {2'd0, 2'd0, 8'h12, 8'd3},   // R3 count 0x1234
        {2'd0, 2'd3, 8'h00, 8'd5},   // R5 latch ch0
        {2'd0, 2'd0, 8'h78, 8'd3},
        {2'd0, 2'd0, 8'h56, 8'd3},   // live 0x5678
        {2'd0, 2'd3, 8'h00, 8'd6},   // R6 ignored
        {2'd1, 2'd0, 8'h34, 8'd5},   // R5
        {2'd1, 2'd0, 8'h12, 8'd5},   // R5
        {2'd1, 2'd0, 8'h78, 8'd9},   // R9
        {2'd1, 2'd0, 8'h56, 8'd9},   // R9
        {2'd0, 2'd3, 8'h50, 8'd1},   // R1 ch1 low only, mode 0
        {2'd0, 2'd3, 8'hE4, 8'd7},   // R7 status only ch1
        {2'd1, 2'd1, 8'h50, 8'd8},   // R8 null set
        {2'd1, 2'd1, 8'h00, 8'd9},   // R9 live low byte
        {2'd0, 2'd1, 8'h77, 8'd3},
        {2'd1, 2'd1, 8'h77, 8'd3},   // R3
        {2'd0, 2'd3, 8'hC6, 8'd7},   // R7 ch0+ch1 both
        {2'd1, 2'd0, 8'h36, 8'd8},   // R8 status first
        {2'd1, 2'd0, 8'h78, 8'd7},   // R7
        {2'd1, 2'd0, 8'h56, 8'd7},   // R7
        {2'd1, 2'd1, 8'h10, 8'd8},   // R8
        {2'd1, 2'd1, 8'h77, 8'd7},   // R7
        {2'd0, 2'd3, 8'hC3, 8'd7},   // R7 bit0 set: ignored
        {2'd1, 2'd0, 8'h78, 8'd7},   // R7
        {2'd1, 2'd0, 8'h56, 8'd7},   // R7
        {2'd0, 2'd3, 8'h60, 8'd1},   // R1 ch1 high only
        {2'd0, 2'd1, 8'hAB, 8'd3},
        {2'd1, 2'd1, 8'hAB, 8'd3},   // R3 high-byte format
        {2'd0, 2'd3, 8'h40, 8'd5},   // R5 latch ch1
        {2'd0, 2'd1, 8'hCD, 8'd3},
        {2'd1, 2'd1, 8'hAB, 8'd5},   // R5
        {2'd1, 2'd1, 8'hCD, 8'd9},   // R9
        {2'd0, 2'd3, 8'hC4, 8'd7},   // R7 ch1 both
        {2'd0, 2'd1, 8'h11, 8'd3},   // live 0x1100
        {2'd0, 2'd3, 8'hC4, 8'd6},   // R6 both ignored
        {2'd1, 2'd1, 8'h20, 8'd8},   // R8
        {2'd1, 2'd1, 8'hCD, 8'd6},   // R6
        {2'd1, 2'd1, 8'h11, 8'd9}    // R9
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 chk(req, rdata, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic run_en(input int ch, input int n);
        @(negedge clk);
        cnt_en[ch] = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en[ch] = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = 2'd0; wdata = '0; cnt_en = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        @(negedge clk);
        chk("R12 rdata", rdata, 8'h00);
        chk("R12 out", {5'd0, out_lvl}, 8'h00);
        chk("R12 mode", mode_o[7:0], 8'h00);
        addr = 2'd3;
        #1 chk("R13 ctrl read", rdata, 8'h00);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k][19:18] == 2'd0) wr(VEC[k][17:16], VEC[k][15:8]);
            else rd(VEC[k][17:16], VEC[k][15:8], $sformatf("R%0d vec %0d", VEC[k][7:0], k));
        end

        // R2 mode decode on channel 2
        wr(2'd3, 8'hBC); chk("R2 x10", {5'd0, mode_o[8:6]}, 8'd2);
        wr(2'd3, 8'hBE); chk("R2 x11", {5'd0, mode_o[8:6]}, 8'd3);
        wr(2'd3, 8'hBA); chk("R2 101", {5'd0, mode_o[8:6]}, 8'd5);
        wr(2'd3, 8'h98); chk("R2 100", {5'd0, mode_o[8:6]}, 8'd4);
        wr(2'd3, 8'hE8);
        rd(2'd2, 8'h58, "R4 null after ctrl");

        // R10 BCD wrap and borrow
        wr(2'd3, 8'hB1);
        wr(2'd2, 8'h00); wr(2'd2, 8'h00);
        run_en(2, 1);
        rd(2'd2, 8'h99, "R10 bcd wrap lo");
        rd(2'd2, 8'h99, "R10 bcd wrap hi");
        wr(2'd2, 8'h00); wr(2'd2, 8'h01);
        run_en(2, 1);
        rd(2'd2, 8'h99, "R10 bcd borrow lo");
        rd(2'd2, 8'h00, "R10 bcd borrow hi");

        // R10 binary wrap
        wr(2'd3, 8'hB0);
        wr(2'd2, 8'h00); wr(2'd2, 8'h00);
        run_en(2, 1);
        rd(2'd2, 8'hFF, "R10 bin wrap lo");
        rd(2'd2, 8'hFF, "R10 bin wrap hi");

        // R11 OUT on 1 -> 0
        wr(2'd3, 8'hB0);
        wr(2'd2, 8'h02); wr(2'd2, 8'h00);
        run_en(2, 1);
        chk("R11 out at 1", {7'd0, out_lvl[2]}, 8'h00);
        run_en(2, 1);
        chk("R11 out at 0", {7'd0, out_lvl[2]}, 8'h01);
        run_en(2, 1);
        chk("R11 out sticky", {7'd0, out_lvl[2]}, 8'h01);
        wr(2'd3, 8'hB0);
        chk("R4 out cleared", {7'd0, out_lvl[2]}, 8'h00);

        // R4 pointer reset: one byte written, then reprogram
        wr(2'd2, 8'h44);
        wr(2'd3, 8'hB0);
        wr(2'd2, 8'h21); wr(2'd2, 8'h43);
        rd(2'd2, 8'h21, "R4 ptr lo");
        rd(2'd2, 8'h43, "R4 ptr hi");

        finish_run();
    end

endmodule